// File: doc/BRIEF.md
# Counter Overflow Interrupt Controller

This block holds a free-running up-counter and turns its wrap events, together with event pulses from three external compare/capture channels, into one interrupt request. The counter advances by one on every clock in which the count enable is high. Two overflow events come from the counter. A full wrap occurs when all of its bits roll over. A partial wrap occurs when a low field rolls over, and that field's width is picked at run time from four choices.

Every event sets its own sticky flag, whatever the enables hold. Software reads the flags and clears them with a masked write, in which a zero bit clears and a one bit leaves the flag alone. The request output combines the flags with a per-source enable mask and two global gates, a system gate and a block gate. The request rises only when both gates are open.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: On each clock with `cnt_en` high, `count` increases by one and wraps from 0xFFFF to 0x0000. With `cnt_en` low, `count` holds its value.
- R2: Flag bit 0 (full overflow) is set in the same clock edge that takes `count` from 0xFFFF to 0x0000.
- R3: Flag bit 1 (partial overflow) is set in the clock edge that takes the low W bits of `count` from all ones to zero. W is 8, 9, 10 or 11 for `mid_sel` values 0, 1, 2 and 3. The flag therefore recurs every 2^W counts.
- R4: A one-cycle pulse on `chan_evt[i]` sets flag bit 2+i at that clock edge, for i from 0 to 2.
- R5: A flag is set by its event even when its bit in `src_en` or either global gate is 0.
- R6: On a clock with `flag_wr` high, each flag whose `flag_wdata` bit is 0 is cleared and each flag whose bit is 1 is kept. Without `flag_wr`, set flags stay set.
- R7: When an event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R8: `irq` equals `sys_en AND blk_en AND OR(flags AND src_en)`. It follows the enable inputs in the same cycle, with no clock in between.
- R9: While `rst_n` is low, `count` and `flags` are zero, and `irq` is therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable |
| mid_sel | input | 2 | Partial-overflow width select (0..3 -> 8..11 bits) |
| chan_evt | input | 3 | Single-cycle channel event pulses |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 5 | Write mask; a 0 bit clears the matching flag |
| src_en | input | 5 | Per-flag interrupt enables, same bit order as flags |
| blk_en | input | 1 | Block-level interrupt gate |
| sys_en | input | 1 | System-level interrupt gate |
| count | output | 16 | Current counter value |
| flags | output | 5 | Event flags: bit 0 full, bit 1 partial, bits 2..4 channels |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter state shows on `count` at the next edge. A mis-selected partial width moves the rise of flag bit 1 away from count 2^W, and the check lands on that exact edge. A flag bank that drops or invents a bit shows on `flags` one edge after the event or the write. A wrong gate term shows on `irq` at once, without any clock edge, when an enable toggles.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

   // Position of each source in the flag and enable vectors.
   localparam int unsigned SRC_FULL = 0;
   localparam int unsigned SRC_MID  = 1;
   localparam int unsigned SRC_CH0  = 2;

   // Partial-overflow width choices, relative to the base width.
   typedef enum logic [1:0] {
      MID_BASE_P0 = 2'd0,
      MID_BASE_P1 = 2'd1,
      MID_BASE_P2 = 2'd2,
      MID_BASE_P3 = 2'd3
   } mid_sel_e;

   // Total number of interrupt sources for a given channel count.
   function automatic int unsigned src_count(input int unsigned chans);
      return chans + 2;
   endfunction

endpackage

// File: rtl/ovf_counter.sv
module ovf_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned MID_BASE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [SEL_W-1:0] mid_sel,
   output logic [CNT_W-1:0] count,
   output logic             full_wrap,
   output logic             mid_wrap
);
   localparam int unsigned SEL_N = 1 << SEL_W;

   if (MID_BASE < 1) begin : g_bad_base
      $error("ovf_counter: MID_BASE must be at least 1");
   end
   if (MID_BASE + SEL_N - 1 >= CNT_W) begin : g_bad_width
      $error("ovf_counter: widest partial field must be narrower than CNT_W");
   end

   logic [SEL_N-1:0] mid_hit;

   // One all-ones detector per selectable field width.
   for (genvar k = 0; k < SEL_N; k++) begin : g_mid
      localparam int unsigned FW = MID_BASE + k;
      assign mid_hit[k] = &count[FW-1:0];
   end

   assign full_wrap = cnt_en & (&count);
   assign mid_wrap  = cnt_en & mid_hit[mid_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_en) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/ovf_flag_bank.sv
module ovf_flag_bank #(
   parameter int unsigned SRC_N = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] set_vec,
   input  logic             wr,
   input  logic [SRC_N-1:0] wdata,
   output logic [SRC_N-1:0] flags
);
   if (SRC_N < 1) begin : g_bad_n
      $error("ovf_flag_bank: SRC_N must be at least 1");
   end

   for (genvar i = 0; i < SRC_N; i++) begin : g_bit
      logic kept;
      // A write keeps the flag only where the mask bit is 1.
      assign kept = wr ? (flags[i] & wdata[i]) : flags[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
         end else begin
            flags[i] <= kept | set_vec[i];   // a set beats a clear
         end
      end
   end

endmodule

// File: rtl/ovf_irq_gate.sv
module ovf_irq_gate #(
   parameter int unsigned SRC_N = 5
) (
   input  logic [SRC_N-1:0] flags,
   input  logic [SRC_N-1:0] src_en,
   input  logic             blk_en,
   input  logic             sys_en,
   output logic             irq
);
   logic pending;

   always_comb begin
      pending = |(flags & src_en);
      irq     = pending & blk_en & sys_en;
   end

endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
   import ovf_irq_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned MID_BASE = 8,
   parameter int unsigned CHAN_N   = 3,
   localparam int unsigned SRC_N   = src_count(CHAN_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [SEL_W-1:0]  mid_sel,
   input  logic [CHAN_N-1:0] chan_evt,
   input  logic              flag_wr,
   input  logic [SRC_N-1:0]  flag_wdata,
   input  logic [SRC_N-1:0]  src_en,
   input  logic              blk_en,
   input  logic              sys_en,
   output logic [CNT_W-1:0]  count,
   output logic [SRC_N-1:0]  flags,
   output logic              irq
);
   if (CHAN_N < 1) begin : g_bad_chan
      $error("ovf_irq_ctrl: CHAN_N must be at least 1");
   end

   logic             full_wrap;
   logic             mid_wrap;
   logic [SRC_N-1:0] set_vec;

   ovf_counter #(
      .CNT_W   (CNT_W),
      .SEL_W   (SEL_W),
      .MID_BASE(MID_BASE)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en   (cnt_en),
      .mid_sel  (mid_sel),
      .count    (count),
      .full_wrap(full_wrap),
      .mid_wrap (mid_wrap)
   );

   always_comb begin
      set_vec                            = '0;
      set_vec[SRC_FULL]                  = full_wrap;
      set_vec[SRC_MID]                   = mid_wrap;
      set_vec[SRC_CH0 +: CHAN_N]         = chan_evt;
   end

   ovf_flag_bank #(
      .SRC_N(SRC_N)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .wr     (flag_wr),
      .wdata  (flag_wdata),
      .flags  (flags)
   );

   ovf_irq_gate #(
      .SRC_N(SRC_N)
   ) u_gate (
      .flags (flags),
      .src_en(src_en),
      .blk_en(blk_en),
      .sys_en(sys_en),
      .irq   (irq)
   );

endmodule

// File: rtl/ovf_irq_checker.sv
module ovf_irq_checker #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned MID_BASE = 8,
   parameter int unsigned CHAN_N   = 3,
   parameter int unsigned SRC_N    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_en,
   input logic [SEL_W-1:0]  mid_sel,
   input logic [CHAN_N-1:0] chan_evt,
   input logic              flag_wr,
   input logic [SRC_N-1:0]  flag_wdata,
   input logic [SRC_N-1:0]  src_en,
   input logic              blk_en,
   input logic              sys_en,
   input logic [CNT_W-1:0]  count,
   input logic [SRC_N-1:0]  flags,
   input logic              irq
);
   logic [CNT_W-1:0] mid_mask;
   always_comb mid_mask = ~({CNT_W{1'b1}} << (MID_BASE + int'(mid_sel)));

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> count == CNT_W'($past(count) + 1'b1));

   p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(count));

   p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && count == {CNT_W{1'b1}}) |=> flags[0]);

   p_mid_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && (count & mid_mask) == mid_mask) |=> flags[1]);

   for (genvar i = 0; i < CHAN_N; i++) begin : g_chan_chk
      p_chan_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
         chan_evt[i] |=> flags[2+i]);
   end

   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> (($past(flags) & ~flags) == '0));

   p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(sys_en && blk_en) |-> !irq);

   p_gate_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_en && blk_en && (flags & src_en) != '0) |-> irq);

   p_no_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & src_en) == '0) |-> !irq);

endmodule

bind ovf_irq_ctrl ovf_irq_checker #(
   .CNT_W   (CNT_W),
   .SEL_W   (SEL_W),
   .MID_BASE(MID_BASE),
   .CHAN_N  (CHAN_N),
   .SRC_N   (SRC_N)
) u_chk (.*);

// File: tb/ovf_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ovf_irq_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic [1:0]  mid_sel = 2'd0;
   logic [2:0]  chan_evt = 3'd0;
   logic        flag_wr = 1'b0;
   logic [4:0]  flag_wdata = 5'd0;
   logic [4:0]  src_en = 5'd0;
   logic        blk_en = 1'b0;
   logic        sys_en = 1'b0;
   logic [15:0] count;
   logic [4:0]  flags;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ovf_irq_ctrl u_ovf_irq_ctrl (.*);

   // {chan[2:0], src_en[4:0], blk, sys, expected irq}
   localparam logic [10:0] VEC [9] = '{
      {3'b001, 5'b00100, 1'b1, 1'b1, 1'b1},
      {3'b001, 5'b00000, 1'b1, 1'b1, 1'b0},
      {3'b010, 5'b01000, 1'b1, 1'b0, 1'b0},
      {3'b100, 5'b10000, 1'b0, 1'b1, 1'b0},
      {3'b100, 5'b10000, 1'b1, 1'b1, 1'b1},
      {3'b011, 5'b10000, 1'b1, 1'b1, 1'b0},
      {3'b111, 5'b11111, 1'b1, 1'b1, 1'b1},
      {3'b000, 5'b11111, 1'b1, 1'b1, 1'b0},
      {3'b110, 5'b00011, 1'b1, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cnt_en = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic run_cnt(input int n);
      cnt_en = 1'b1;
      repeat (n) step();
      cnt_en = 1'b0;
   endtask

   task automatic clear_all();
      flag_wr = 1'b1;
      flag_wdata = 5'b00000;
      step();
      flag_wr = 1'b0;
      flag_wdata = 5'b11111;
   endtask

   initial begin
      do_reset();
      // R9: reset state
      check("R9 count", count, 0);
      check("R9 flags", flags, 0);
      check("R9 irq", irq, 0);

      // R4 R5 R8: table of channel events against enables and gates
      for (int v = 0; v < 9; v++) begin
         src_en = 5'b0;
         blk_en = 1'b0;
         sys_en = 1'b0;
         clear_all();
         chan_evt = VEC[v][10:8];
         step();
         chan_evt = 3'b0;
         check("R4 R5 flags", flags, {VEC[v][10:8], 2'b00});
         src_en = VEC[v][7:3];
         blk_en = VEC[v][2];
         sys_en = VEC[v][1];
         #1;
         check("R8 irq", irq, VEC[v][0]);
      end

      // R1: counting and holding
      src_en = 5'b0;
      do_reset();
      run_cnt(37);
      check("R1 count step", count, 37);
      step();
      step();
      check("R1 count hold", count, 37);

      // R3: partial overflow at each width choice
      for (int s = 0; s < 4; s++) begin
         do_reset();
         mid_sel = 2'(s);
         run_cnt((1 << (8 + s)) - 1);
         check("R3 before wrap", flags[1], 0);
         run_cnt(1);
         check("R3 at wrap", flags[1], 1);
         check("R3 count", count, 1 << (8 + s));
         check("R3 no full", flags[0], 0);
      end

      // R2: full wrap
      do_reset();
      mid_sel = 2'd3;
      run_cnt(65535);
      check("R2 count top", count, 16'hFFFF);
      check("R2 before wrap", flags[0], 0);
      run_cnt(1);
      check("R2 count wrapped", count, 0);
      check("R2 at wrap", flags[0], 1);

      // R6: masked clear and hold
      chan_evt = 3'b101;
      step();
      chan_evt = 3'b0;
      check("R6 setup", flags, 5'b10111);
      step();
      check("R6 hold", flags, 5'b10111);
      flag_wr = 1'b1;
      flag_wdata = 5'b11110;
      step();
      flag_wr = 1'b0;
      check("R6 clear bit0", flags, 5'b10110);

      // R7: set wins over clear in the same cycle
      flag_wr = 1'b1;
      flag_wdata = 5'b00000;
      chan_evt = 3'b010;
      step();
      flag_wr = 1'b0;
      chan_evt = 3'b0;
      check("R7 set wins", flags, 5'b01000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule